// File: doc/BRIEF.md
# Spread-Spectrum Burst Preamble Framer

This block builds one transmit burst for a spread-spectrum link that carries short control messages in bursts. A pulse on the start input begins a synchronization preamble of 42 bits. The preamble alternates between one and zero and ends on two ones, so a receiver can lock onto the bit timing and then find the point where data begins. After the preamble, the block sends a 32-bit control word one bit at a time, most significant bit first.

Every bit, whether preamble or data, occupies eleven chip periods. During those periods the bit is combined by exclusive-OR with an eleven-chip spreading code. The result leaves the block on a single registered chip output. When no burst is active, that output rests low.

One clock cycle equals one chip. A 6-bit counter tracks the preamble bits. A single decode at the end of the preamble switches the bit source from the preamble to a loaded shift register. The same decode takes a copy of the control word, so the word only has to be valid at that moment.

Top module: `burst_framer`

## Requirements
- R1: After reset, chip_out is 0 and remains 0 for as long as start stays low.
- R2: The clock edge that samples start high begins a burst. Chip j of the burst (j = 0 .. 813) appears on chip_out right after edge j+1 counted from that edge. A burst has (42 + 32) x 11 = 814 chips.
- R3: Preamble bit n (n = 0 .. 41) is 1 for even n and 0 for odd n, except bit 41, which is 1. The preamble therefore ends 1,0,1,1.
- R4: Each bit lasts 11 chips. Chip k (k = 0 .. 10) of a bit is the bit XOR c[k], where c = 0,0,0,1,1,1,0,1,1,0,1 in that order.
- R5: The control word is captured on the clock edge that ends the last chip of preamble bit 41, which is edge 462 after the start edge. Values of ctrl_word before or after that edge have no effect on the burst.
- R6: Burst bits 42 .. 73 carry the captured word ctrl_word[31] down to ctrl_word[0], most significant bit first.
- R7: After chip 813 of a burst, chip_out returns to 0 and stays 0 until the next start.
- R8: A start sampled while a burst is in progress abandons that burst. A new burst then begins with preamble bit 0, with the same timing as R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock; one cycle per chip |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a burst (also restarts a burst in progress) |
| ctrl_word | input | 32 | Control word, sampled at the end of the preamble |
| chip_out | output | 1 | Registered spread chip stream; 0 when idle |

## Verification
The start edge is edge 0. Chip j is due on chip_out one register stage later, right after edge j+1. The bench waits for that edge and then samples at the following falling edge. It compares every chip of a burst with a value computed from the bit index j/11 and the chip index j%11.

For R5, the capture edge is edge 462. The bench writes the intended word at the falling edge just before that edge, and writes a different value at the falling edge just after it. For R8, a second start is issued 600 chips into a burst, during the data phase. The new burst is then checked from chip 0 with the same offset of one cycle. For R7, the 16 cycles after chip 813 are checked for a low output.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Burst phase shared by the sequencer, the output mux and the checker.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // Width needed to count 0 .. n-1 (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/burst_chip_gen.sv
// Circulating spreading-code register. It is preset at reset and at each
// start, and it rotates once per chip while a burst runs. Because the burst
// length is a whole number of code periods, the register is back at its
// preset value when the burst ends.
module burst_chip_gen #(
  parameter int                    SPREAD_LEN = 11,
  parameter logic [SPREAD_LEN-1:0] SPREAD_SEQ = 11'b00011101101
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic chip
);

  logic [SPREAD_LEN-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      code_q <= SPREAD_SEQ;
    end else if (run) begin
      code_q <= {code_q[SPREAD_LEN-2:0], code_q[SPREAD_LEN-1]};
    end
  end

  assign chip = code_q[SPREAD_LEN-1];

endmodule

// File: rtl/burst_bit_seq.sv
// Timing for the burst: chip-in-bit timer, preamble bit counter, sticky
// end-of-preamble flag and phase register.
module burst_bit_seq
  import burst_pkg::*;
#(
  parameter int SPREAD_LEN = 11,
  parameter int PRE_LEN    = 42
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   data_last,
  output logic   bit_strobe,
  output logic   pre_bit,
  output logic   load_pulse,
  output phase_e phase
);

  localparam int CHIP_W = idx_width(SPREAD_LEN);
  localparam int CNT_W  = idx_width(PRE_LEN + 1);
  localparam logic [CHIP_W-1:0] CHIP_LAST = CHIP_W'(SPREAD_LEN - 1);
  localparam logic [CNT_W-1:0]  CNT_HOLD  = CNT_W'(PRE_LEN - 2);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0]  CNT_SAT   = CNT_W'(PRE_LEN);

  logic [CHIP_W-1:0] chip_idx_q;
  logic [CNT_W-1:0]  pre_cnt_q;
  logic              hold_q;
  phase_e            phase_q;

  assign bit_strobe = (phase_q != PH_IDLE) && (chip_idx_q == CHIP_LAST);
  assign load_pulse = bit_strobe && (phase_q == PH_PRE) && (pre_cnt_q == CNT_LAST);
  // The counter LSB gives the alternating pattern. Once the sticky flag is
  // set, it overrides the LSB and holds the bit at 1.
  assign pre_bit    = ~pre_cnt_q[0] | hold_q;
  assign phase      = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_idx_q <= '0;
      pre_cnt_q  <= '0;
      hold_q     <= 1'b0;
      phase_q    <= PH_IDLE;
    end else if (start) begin
      chip_idx_q <= '0;
      pre_cnt_q  <= '0;
      hold_q     <= 1'b0;
      phase_q    <= PH_PRE;
    end else if (phase_q != PH_IDLE) begin
      chip_idx_q <= bit_strobe ? '0 : chip_idx_q + 1'b1;
      if (bit_strobe) begin
        unique case (phase_q)
          PH_PRE: begin
            if (pre_cnt_q == CNT_HOLD) begin
              hold_q <= 1'b1;
            end
            if (pre_cnt_q == CNT_LAST) begin
              pre_cnt_q <= CNT_SAT;
              phase_q   <= PH_DATA;
            end else begin
              pre_cnt_q <= pre_cnt_q + 1'b1;
            end
          end
          PH_DATA: begin
            if (data_last) begin
              phase_q <= PH_IDLE;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/burst_word_shifter.sv
// Loadable shift register that sends the control word out, most significant
// bit first. It advances one bit per bit strobe during the data phase.
module burst_word_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] word,
  output logic              ser_bit,
  output logic              last
);

  localparam int DCNT_W = burst_pkg::idx_width(WORD_W);
  localparam logic [DCNT_W-1:0] DCNT_LAST = DCNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sreg_q;
  logic [DCNT_W-1:0] dcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      dcnt_q <= '0;
    end else if (load) begin
      sreg_q <= word;
      dcnt_q <= '0;
    end else if (shift) begin
      sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      dcnt_q <= dcnt_q + 1'b1;
    end
  end

  assign ser_bit = sreg_q[WORD_W-1];
  assign last    = (dcnt_q == DCNT_LAST);

endmodule

// File: rtl/burst_framer.sv
module burst_framer
  import burst_pkg::*;
#(
  parameter int                    WORD_W     = 32,
  parameter int                    PRE_LEN    = 42,
  parameter int                    SPREAD_LEN = 11,
  parameter logic [SPREAD_LEN-1:0] SPREAD_SEQ = 11'b00011101101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] ctrl_word,
  output logic              chip_out
);

  phase_e phase;
  logic   bit_strobe;
  logic   pre_bit;
  logic   load_pulse;
  logic   ser_bit;
  logic   data_last;
  logic   chip;
  logic   sel_bit;
  logic   chip_nxt;

  burst_bit_seq #(
    .SPREAD_LEN (SPREAD_LEN),
    .PRE_LEN    (PRE_LEN)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .data_last  (data_last),
    .bit_strobe (bit_strobe),
    .pre_bit    (pre_bit),
    .load_pulse (load_pulse),
    .phase      (phase)
  );

  burst_word_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (load_pulse),
    .shift   (bit_strobe && (phase == PH_DATA)),
    .word    (ctrl_word),
    .ser_bit (ser_bit),
    .last    (data_last)
  );

  burst_chip_gen #(
    .SPREAD_LEN (SPREAD_LEN),
    .SPREAD_SEQ (SPREAD_SEQ)
  ) u_code (
    .clk     (clk),
    .rst     (rst),
    .restart (start),
    .run     (phase != PH_IDLE),
    .chip    (chip)
  );

  // Output mux: preamble bit or serialized data, spread by the current chip.
  always_comb begin
    sel_bit  = (phase == PH_DATA) ? ser_bit : pre_bit;
    chip_nxt = (phase == PH_IDLE) ? 1'b0 : (sel_bit ^ chip);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_out <= 1'b0;
    end else begin
      chip_out <= chip_nxt;
    end
  end

endmodule

// File: rtl/burst_framer_chk.sv
module burst_framer_chk
  import burst_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   start,
  input logic   chip_out,
  input phase_e phase,
  input logic   bit_strobe,
  input logic   pre_bit,
  input logic   load_pulse
);

  // R7 / R1: an idle cycle leads to a low chip on the output register.
  a_r7_idle_low: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |=> !chip_out);

  // R8: a start always (re)enters the preamble phase.
  a_r8_restart_pre: assert property (@(posedge clk) disable iff (rst)
    start |=> (phase == PH_PRE));

  // R5: the load is a single-cycle pulse that moves the burst into data.
  a_r5_load_single: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> !load_pulse);

  a_r5_load_to_data: assert property (@(posedge clk) disable iff (rst)
    (load_pulse && !start) |=> (phase == PH_DATA));

  // R3: the last preamble bit, sent at the load point, is a one.
  a_r3_last_pre_high: assert property (@(posedge clk) disable iff (rst)
    load_pulse |-> pre_bit);

  // R4: the preamble bit changes only at a bit boundary.
  a_r4_bit_stable: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_PRE) && !bit_strobe && !start) |=> $stable(pre_bit));

  // R6: the data phase never falls back into the preamble without a start.
  a_r6_no_return: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_DATA) && !start) |=> (phase != PH_PRE));

endmodule

bind burst_framer burst_framer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .chip_out   (chip_out),
  .phase      (phase),
  .bit_strobe (bit_strobe),
  .pre_bit    (pre_bit),
  .load_pulse (load_pulse)
);

// File: tb/tb_burst_framer.sv
`timescale 1ns/1ps
module tb_burst_framer;

  localparam int WORD_W     = 32;
  localparam int PRE_LEN    = 42;
  localparam int SPREAD_LEN = 11;
  localparam logic [SPREAD_LEN-1:0] SEQ = 11'b00011101101;
  localparam int BURST      = (PRE_LEN + WORD_W) * SPREAD_LEN;
  localparam int PRE_CHIPS  = PRE_LEN * SPREAD_LEN;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [WORD_W-1:0] ctrl_word = '0;
  logic              chip_out;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  burst_framer dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ctrl_word (ctrl_word),
    .chip_out  (chip_out)
  );

  // Expected chip j of a burst carrying word w (R3, R4, R6).
  function automatic logic exp_chip(input int j, input logic [WORD_W-1:0] w);
    int   b;
    int   k;
    logic bv;
    b = j / SPREAD_LEN;
    k = j % SPREAD_LEN;
    if (b < PRE_LEN) bv = (b == PRE_LEN - 1) ? 1'b1 : ((b % 2) == 0);
    else             bv = w[WORD_W - 1 - (b - PRE_LEN)];
    return bv ^ SEQ[SPREAD_LEN - 1 - k];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Runs a burst. w_start is driven with start, w_cap just before the capture
  // edge, w_post just after it. stop_at < 0 runs the whole burst and checks
  // the idle tail; otherwise the burst is left after stop_at chips.
  task automatic run_burst(input logic [WORD_W-1:0] w_start,
                           input logic [WORD_W-1:0] w_cap,
                           input logic [WORD_W-1:0] w_post,
                           input int stop_at, input string pre_req,
                           input string data_req);
    int limit;
    int pre_bad_at  = -1;
    int data_bad_at = -1;
    int pre_act = 0, pre_exp = 0, data_act = 0, data_exp = 0;
    limit = (stop_at < 0) ? BURST : stop_at;
    @(negedge clk);
    ctrl_word = w_start;
    start     = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < limit; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (chip_out !== exp_chip(j, w_cap)) begin
        if (j < PRE_CHIPS && pre_bad_at < 0) begin
          pre_bad_at = j; pre_act = int'(chip_out); pre_exp = int'(exp_chip(j, w_cap));
        end
        if (j >= PRE_CHIPS && data_bad_at < 0) begin
          data_bad_at = j; data_act = int'(chip_out); data_exp = int'(exp_chip(j, w_cap));
        end
      end
      if (j == PRE_CHIPS - 2) ctrl_word = w_cap;
      if (j == PRE_CHIPS - 1) ctrl_word = w_post;
    end
    if (pre_bad_at >= 0)
      $display("  first preamble mismatch at chip %0d", pre_bad_at);
    check(pre_bad_at < 0, pre_req, "preamble chip stream", pre_act, pre_exp);
    if (stop_at < 0) begin
      if (data_bad_at >= 0)
        $display("  first data mismatch at chip %0d", data_bad_at);
      check(data_bad_at < 0, data_req, "data chip stream", data_act, data_exp);
      begin
        int high_cnt = 0;
        for (int i = 0; i < 16; i++) begin
          @(posedge clk);
          @(negedge clk);
          if (chip_out !== 1'b0) high_cnt++;
        end
        check(high_cnt == 0, "R7", "idle chips high after burst", high_cnt, 0);
      end
    end
  endtask

  initial begin
    int seed_dummy;
    int high_cnt;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: quiet output after reset with start low.
    high_cnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (chip_out !== 1'b0) high_cnt++;
    end
    check(high_cnt == 0, "R1", "chips high after reset", high_cnt, 0);

    // Directed words: all zero, all one, end bits only (R6 ordering).
    run_burst(32'h0000_0000, 32'h0000_0000, 32'h0000_0000, -1, "R2 R3 R4", "R6");
    run_burst(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, -1, "R2 R3 R4", "R6");
    run_burst(32'h8000_0001, 32'h8000_0001, 32'h8000_0001, -1, "R2 R3 R4", "R6");

    // R5: only the value present at the capture edge is sent.
    run_burst(32'h1234_5678, 32'hA5C3_0F96, 32'h5A3C_F069, -1, "R3 R4", "R5 R6");

    // R8: restart during the data phase, then a complete new burst.
    run_burst(32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 600, "R3", "R6");
    run_burst(32'h0F0F_3C3C, 32'hC001_D00D, 32'h0F0F_3C3C, -1, "R8 R3", "R8 R5 R6");

    // Random words, also changed around the capture edge.
    for (int n = 0; n < 5; n++) begin
      logic [WORD_W-1:0] wa, wb, wc;
      wa = $urandom;
      wb = $urandom;
      wc = $urandom;
      run_burst(wa, wb, wc, -1, "R2 R3 R4", "R5 R6");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL R2 watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule